// File: doc/BRIEF.md
# Floating-Point Register Ready-Bit Scoreboard

This block guards a 32-entry floating-point register file against read-after-write and write-after-write races between arithmetic units of different latency. It keeps one ready flag per register instead of comparing the decoded operands against every stage of every unit. The decode stage presents up to two source register numbers and a destination register number. For each source it also gives a flag that says whether a bypass path can deliver the value in time. The block answers with a stall in the same cycle.

An instruction that issues and writes a register clears that register's ready flag. The block also hands the instruction a small generation tag, which travels with it down its unit. When a unit finishes, it presents the destination and the tag. The block grants the register-file write, and sets the flag again, only if that tag still names the newest pending writer of the register. An older write that a younger writer has overtaken is refused. Because that older write is refused, it cannot mark the register ready while the younger result is still on its way.

Top module: `fp_ready_scoreboard`

## Requirements
- R1: After reset every register is ready, so a valid instruction that reads any register without bypass does not stall.
- R2: When a valid, non-stalled instruction with `dec_wr` set issues, its destination becomes not ready from the next cycle onward.
- R3: `stall` is 1 exactly when `dec_valid` is 1 and, for source A or for source B, the operand is used, its register is not ready, and its bypass flag is 0. An unused or bypassable operand never causes a stall.
- R4: A completion with `cmp_valid` set, whose `cmp_tag` equals the newest tag issued for `cmp_dst` while that register is not ready, drives `cmp_we` to 1 in the same cycle and makes the register ready from the next cycle.
- R5: A completion whose tag is not the newest for its register, or whose register is already ready, drives `cmp_we` to 0 and leaves the ready flag unchanged.
- R6: If an issue and a granted completion name the same register in the same cycle, the register stays not ready, and the completion is still granted.
- R7: A stalled instruction changes no ready flag and does not advance any generation tag.
- R8: `iss_tag` for a writer equals the previous tag issued to the same destination plus one, modulo 2^TAG_W. Each register starts at generation 0 after reset, so the first tag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_use_a | input | 1 | Source A is read |
| dec_src_a | input | ADDR_W | Source A register number |
| dec_byp_a | input | 1 | Source A can be bypassed |
| dec_use_b | input | 1 | Source B is read |
| dec_src_b | input | ADDR_W | Source B register number |
| dec_byp_b | input | 1 | Source B can be bypassed |
| dec_wr | input | 1 | The instruction writes a register |
| dec_dst | input | ADDR_W | Destination register number |
| stall | output | 1 | Hold the decode instruction this cycle |
| iss_tag | output | TAG_W | Generation tag for the issuing writer |
| cmp_valid | input | 1 | A unit presents a finished result |
| cmp_dst | input | ADDR_W | Destination register of the finished result |
| cmp_tag | input | TAG_W | Tag carried by the finished instruction |
| cmp_we | output | 1 | Register-file write enable for the finished result |

## Verification
The assertions take for granted that a completion only carries a tag that the block issued earlier for the same register. They also take for granted that fewer than 2^TAG_W writes to one register are in flight at once, because otherwise a stale tag could alias the newest one. The stimulus keeps to both: it draws completions only from a bench-side list of issued writes, and it caps that list at six entries. The tag wrap is driven by issuing and retiring one register's writes in pairs, so two writes to that register are never in flight together.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;

    localparam int FPSB_ADDR_W = 5;
    localparam int FPSB_TAG_W  = 3;

    // An operand holds decode when it is read, pending and not forwardable.
    function automatic logic opnd_blocked(input logic used,
                                          input logic rdy,
                                          input logic byp);
        return used & ~rdy & ~byp;
    endfunction

endpackage

// File: rtl/fpsb_entry.sv
module fpsb_entry #(
    parameter int TAG_W = fpsb_pkg::FPSB_TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_hit,
    input  logic             cmp_hit,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             ready,
    output logic [TAG_W-1:0] gen,
    output logic             wr_ok
);

    localparam logic [TAG_W-1:0] GEN_ONE = TAG_W'(1);

    typedef struct packed {
        logic             ready;
        logic [TAG_W-1:0] gen;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_ok = cmp_hit && !st_q.ready && (cmp_tag == st_q.gen);
        if (issue_hit) begin
            st_d.ready = 1'b0;
            st_d.gen   = st_q.gen + GEN_ONE;
        end else if (wr_ok) begin
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ready: 1'b1, gen: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;
    assign gen   = st_q.gen;

endmodule

// File: rtl/fpsb_hazard.sv
module fpsb_hazard #(
    parameter int ADDR_W = fpsb_pkg::FPSB_ADDR_W,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic [NREG-1:0]   rdy_vec,
    input  logic              dec_valid,
    input  logic              dec_use_a,
    input  logic [ADDR_W-1:0] dec_src_a,
    input  logic              dec_byp_a,
    input  logic              dec_use_b,
    input  logic [ADDR_W-1:0] dec_src_b,
    input  logic              dec_byp_b,
    input  logic              dec_wr,
    output logic              stall,
    output logic              issue_wr
);

    logic blk_a, blk_b;

    always_comb begin
        blk_a    = fpsb_pkg::opnd_blocked(dec_use_a, rdy_vec[dec_src_a], dec_byp_a);
        blk_b    = fpsb_pkg::opnd_blocked(dec_use_b, rdy_vec[dec_src_b], dec_byp_b);
        stall    = dec_valid && (blk_a || blk_b);
        issue_wr = dec_valid && !stall && dec_wr;
    end

endmodule

// File: rtl/fp_ready_scoreboard.sv
module fp_ready_scoreboard #(
    parameter int ADDR_W = fpsb_pkg::FPSB_ADDR_W,
    parameter int TAG_W  = fpsb_pkg::FPSB_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic              dec_use_a,
    input  logic [ADDR_W-1:0] dec_src_a,
    input  logic              dec_byp_a,
    input  logic              dec_use_b,
    input  logic [ADDR_W-1:0] dec_src_b,
    input  logic              dec_byp_b,
    input  logic              dec_wr,
    input  logic [ADDR_W-1:0] dec_dst,
    output logic              stall,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cmp_valid,
    input  logic [ADDR_W-1:0] cmp_dst,
    input  logic [TAG_W-1:0]  cmp_tag,
    output logic              cmp_we
);

    localparam int NREG = 1 << ADDR_W;
    localparam logic [TAG_W-1:0] GEN_ONE = TAG_W'(1);

    logic [NREG-1:0]  rdy_vec;
    logic [NREG-1:0]  ok_vec;
    logic [TAG_W-1:0] gen_vec [NREG];
    logic             issue_wr;

    fpsb_hazard #(.ADDR_W(ADDR_W)) hz_i (
        .rdy_vec   (rdy_vec),
        .dec_valid (dec_valid),
        .dec_use_a (dec_use_a),
        .dec_src_a (dec_src_a),
        .dec_byp_a (dec_byp_a),
        .dec_use_b (dec_use_b),
        .dec_src_b (dec_src_b),
        .dec_byp_b (dec_byp_b),
        .dec_wr    (dec_wr),
        .stall     (stall),
        .issue_wr  (issue_wr)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        fpsb_entry #(.TAG_W(TAG_W)) ent_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue_hit (issue_wr && (dec_dst == ADDR_W'(i))),
            .cmp_hit   (cmp_valid && (cmp_dst == ADDR_W'(i))),
            .cmp_tag   (cmp_tag),
            .ready     (rdy_vec[i]),
            .gen       (gen_vec[i]),
            .wr_ok     (ok_vec[i])
        );
    end

    assign iss_tag = gen_vec[dec_dst] + GEN_ONE;
    assign cmp_we  = |ok_vec;

endmodule

// File: rtl/fp_ready_scoreboard_chk.sv
module fp_ready_scoreboard_chk #(
    parameter int ADDR_W = fpsb_pkg::FPSB_ADDR_W,
    localparam int NREG  = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic              dec_use_a,
    input logic              dec_byp_a,
    input logic              dec_use_b,
    input logic              dec_byp_b,
    input logic              dec_wr,
    input logic [ADDR_W-1:0] dec_dst,
    input logic              stall,
    input logic              cmp_valid,
    input logic [ADDR_W-1:0] cmp_dst,
    input logic              cmp_we,
    input logic [NREG-1:0]   rdy_vec
);

    logic iss, same;
    assign iss  = dec_valid && !stall && dec_wr;
    assign same = iss && (dec_dst == cmp_dst);

    AST_STALL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> dec_valid); // R3

    AST_FREE_OPERANDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (!dec_use_a || dec_byp_a) && (!dec_use_b || dec_byp_b)) |-> !stall); // R3

    AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        iss |=> !rdy_vec[$past(dec_dst)]); // R2

    AST_GRANT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !same) |=> rdy_vec[$past(cmp_dst)]); // R4

    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |-> cmp_valid); // R4

    AST_REFUSED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_we && !same) |=> (rdy_vec[$past(cmp_dst)] == $past(rdy_vec[cmp_dst]))); // R5

    AST_ISSUE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && same) |=> !rdy_vec[$past(cmp_dst)]); // R6

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !cmp_valid) |=> $stable(rdy_vec)); // R7

endmodule

bind fp_ready_scoreboard fp_ready_scoreboard_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_use_a (dec_use_a),
    .dec_byp_a (dec_byp_a),
    .dec_use_b (dec_use_b),
    .dec_byp_b (dec_byp_b),
    .dec_wr    (dec_wr),
    .dec_dst   (dec_dst),
    .stall     (stall),
    .cmp_valid (cmp_valid),
    .cmp_dst   (cmp_dst),
    .cmp_we    (cmp_we),
    .rdy_vec   (rdy_vec)
);

// File: tb/fp_ready_scoreboard_tb_top.sv
module fp_ready_scoreboard_tb_top;

    localparam int AW = 5;
    localparam int TW = 3;
    localparam int NR = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_use_a = 0, dec_byp_a = 0, dec_use_b = 0, dec_byp_b = 0, dec_wr = 0;
    logic [AW-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0, cmp_dst = '0;
    logic cmp_valid = 0;
    logic [TW-1:0] cmp_tag = '0;
    logic stall, cmp_we;
    logic [TW-1:0] iss_tag;

    always #10 clk = ~clk;

    fp_ready_scoreboard #(.ADDR_W(AW), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_use_a(dec_use_a), .dec_src_a(dec_src_a), .dec_byp_a(dec_byp_a),
        .dec_use_b(dec_use_b), .dec_src_b(dec_src_b), .dec_byp_b(dec_byp_b),
        .dec_wr(dec_wr), .dec_dst(dec_dst), .stall(stall), .iss_tag(iss_tag),
        .cmp_valid(cmp_valid), .cmp_dst(cmp_dst), .cmp_tag(cmp_tag), .cmp_we(cmp_we)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int ref_rdy [NR];
    int ref_gen [NR];
    int pend_dst [$];
    int pend_tag [$];

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_dec(input bit v, input bit ua, input int sa, input bit ba,
                           input bit ub, input int sb, input bit bb,
                           input bit w, input int d);
        dec_valid = v; dec_use_a = ua; dec_src_a = AW'(sa); dec_byp_a = ba;
        dec_use_b = ub; dec_src_b = AW'(sb); dec_byp_b = bb;
        dec_wr = w; dec_dst = AW'(d);
    endtask

    task automatic set_cmp(input bit v, input int d, input int t);
        cmp_valid = v; cmp_dst = AW'(d); cmp_tag = TW'(t);
    endtask

    // One cycle: inputs already driven after a falling edge; check, then advance model.
    task automatic tick(input string lbl);
        int  e_stall, e_we, e_tag;
        bit  blk_a, blk_b, iss;
        #5;
        blk_a   = dec_use_a && ref_rdy[dec_src_a] == 0 && !dec_byp_a;
        blk_b   = dec_use_b && ref_rdy[dec_src_b] == 0 && !dec_byp_b;
        e_stall = (dec_valid && (blk_a || blk_b)) ? 1 : 0;
        e_we    = (cmp_valid && ref_rdy[cmp_dst] == 0 && ref_gen[cmp_dst] == int'(cmp_tag)) ? 1 : 0;
        e_tag   = (ref_gen[dec_dst] + 1) % (1 << TW);
        iss     = dec_valid && e_stall == 0 && dec_wr;
        chk(lbl, int'(stall), e_stall);
        if (cmp_valid) chk(e_we ? "R4" : "R5", int'(cmp_we), e_we);
        if (iss) chk("R8", int'(iss_tag), e_tag);
        @(posedge clk);
        if (e_we == 1 && !(iss && dec_dst == cmp_dst)) ref_rdy[cmp_dst] = 1;
        if (iss) begin
            ref_rdy[dec_dst] = 0;
            ref_gen[dec_dst] = e_tag;
            pend_dst.push_back(int'(dec_dst));
            pend_tag.push_back(e_tag);
        end
        @(negedge clk);
        set_dec(0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_cmp(0, 0, 0);
    endtask

    task automatic retire(input int d, input int t);
        for (int k = 0; k < pend_dst.size(); k++) begin
            if (pend_dst[k] == d && pend_tag[k] == t) begin
                pend_dst.delete(k);
                pend_tag.delete(k);
                break;
            end
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin ref_rdy[r] = 1; ref_gen[r] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register readable right after reset
        for (int r = 0; r < NR; r++) begin
            set_dec(1, 1, r, 0, 1, (r + 7) % NR, 0, 0, 0);
            tick("R1");
        end

        // R2 / R3: pending write blocks readers without bypass
        set_dec(1, 0, 0, 0, 0, 0, 0, 1, 5); tick("R2");
        set_dec(1, 1, 5, 0, 0, 0, 0, 0, 0); tick("R2");
        set_dec(1, 1, 5, 1, 0, 0, 0, 0, 0); tick("R3");
        set_dec(1, 0, 5, 0, 0, 0, 0, 0, 0); tick("R3");
        set_dec(1, 1, 1, 0, 1, 5, 0, 0, 0); tick("R3");
        set_dec(0, 1, 5, 0, 1, 5, 0, 0, 0); tick("R3");

        // R4: matching completion frees the register
        set_cmp(1, 5, 1); retire(5, 1); tick("R4");
        set_dec(1, 1, 5, 0, 0, 0, 0, 0, 0); tick("R4");

        // R5: overtaken older write is refused and leaves the register pending
        set_dec(1, 0, 0, 0, 0, 0, 0, 1, 7); tick("R8");
        set_dec(1, 0, 0, 0, 0, 0, 0, 1, 7); tick("R8");
        set_cmp(1, 7, 1); retire(7, 1); tick("R5");
        set_dec(1, 1, 7, 0, 0, 0, 0, 0, 0); tick("R5");
        set_cmp(1, 7, 2); retire(7, 2); tick("R4");
        set_cmp(1, 7, 2); tick("R5");

        // R6: issue and grant on the same register in one cycle
        set_dec(1, 0, 0, 0, 0, 0, 0, 1, 9); tick("R6");
        set_dec(1, 0, 0, 0, 0, 0, 0, 1, 9); set_cmp(1, 9, 1); retire(9, 1); tick("R6");
        set_dec(1, 0, 0, 0, 1, 9, 0, 0, 0); tick("R6");
        set_cmp(1, 9, 2); retire(9, 2); tick("R6");

        // R7: stalled writer leaves its destination ready and its tag unchanged
        set_dec(1, 0, 0, 0, 0, 0, 0, 1, 10); tick("R7");
        set_dec(1, 1, 10, 0, 0, 0, 0, 1, 11); tick("R7");
        set_dec(1, 1, 11, 0, 0, 0, 0, 0, 0); tick("R7");
        set_dec(1, 0, 0, 0, 0, 0, 0, 1, 11); tick("R7");
        set_cmp(1, 11, 1); retire(11, 1); tick("R7");
        set_cmp(1, 10, 1); retire(10, 1); tick("R7");

        // R8: tag wraps modulo 2^TW
        for (int k = 0; k < 10; k++) begin
            set_dec(1, 0, 0, 0, 0, 0, 0, 1, 12); tick("R8");
            set_cmp(1, 12, ref_gen[12]); retire(12, ref_gen[12]); tick("R8");
        end

        // Mixed traffic against the model
        for (int c = 0; c < 1500; c++) begin
            bit w;
            w = (pend_dst.size() < 6) && ($urandom_range(0, 2) == 0);
            set_dec($urandom_range(0, 3) != 0,
                    $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3) == 0,
                    $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3) == 0,
                    w, $urandom_range(0, 7));
            if (pend_dst.size() > 0 && $urandom_range(0, 2) == 0) begin
                int k;
                k = $urandom_range(0, pend_dst.size() - 1);
                set_cmp(1, pend_dst[k], pend_tag[k]);
                pend_dst.delete(k);
                pend_tag.delete(k);
            end
            tick("R3");
        end

        done = 1;
        report();
        $finish;
    end

endmodule